// File: doc/BRIEF.md
# Exception cause priority selector

This block is purely combinational. It sits after the execution units of a 64-bit core and chooses which trap cause to report when several exceptions are raised by one instruction at the same time. The input is a 16-bit flag vector in which bit *n* stands for trap cause *n*. The output is a single "something trapped" bit and the 4-bit cause of the winning exception.

The winner is not the lowest or the highest bit index. It is taken from a fixed architectural ranking. Before ranking, the flags pass through three filters:
- a per-unit enable mask, so that each execution unit forwards only the causes it is able to raise;
- a fetch-only mode, which keeps just the instruction-fetch causes;
- a permanent mask on the two cause numbers that are never defined.

Top module: `exc_cause_sel`

## Requirements
- R1: Flag bit n of `exc_raised` stands for cause n. The defined causes are: 0 fetch misaligned, 1 fetch access fault, 2 illegal instruction, 3 breakpoint, 4 load misaligned, 5 load access fault, 6 store misaligned, 7 store access fault, 8 user ecall, 9 supervisor ecall, 11 machine ecall, 12 fetch page fault, 13 load page fault, 15 store page fault. With a single defined flag raised, fully enabled and fetch-only low, `exc_cause` equals that flag's index.
- R2: When several surviving flags are raised, the reported cause is the one ranked highest in this order, highest first: 3, 12, 1, 2, 0, 11, 9, 8, 6, 4, 15, 13, 7, 5.
- R3: Flags 10 and 14 never take part in selection. On their own they give `exc_valid` = 0, and they never change the reported cause.
- R4: While `fetch_only` is 1, only causes 0, 1, 2 and 12 can be selected. Every other flag is treated as clear.
- R5: A flag whose bit in `unit_cause_en` is 0 is treated as clear.
- R6: `exc_valid` is 1 exactly when at least one flag survives all masks.
- R7: `exc_cause` is 0 whenever `exc_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| exc_raised | input | 16 | Raised exception flags, one bit per cause number |
| unit_cause_en | input | 16 | Per-cause enable; a 0 bit masks that flag |
| fetch_only | input | 1 | When 1, keep only the fetch-side causes 0, 1, 2, 12 |
| exc_valid | output | 1 | At least one flag survives masking |
| exc_cause | output | 4 | Cause number of the highest-ranked surviving flag, 0 if none |

## Verification
The hardest cases to reach from the ports are the ones where a ranking decision depends on both the ranking and the masking. Example: a high-ranked flag is suppressed by the enable mask or by fetch-only mode, so a lower-ranked flag must win. A random sweep rarely lines these up, so the stimulus is built on purpose. Every pair of ranked causes is raised together. The all-ones flag vector is driven while the enable mask walks a single bit. The fetch-only sweep runs with all other causes raised as well. Random multi-flag vectors with random masks then check the remaining combinations against a model that walks the ranking.

// File: rtl/exc_sel_pkg.sv
package exc_sel_pkg;

  localparam int NUM_CAUSE = 16;
  localparam int CAUSE_W   = $clog2(NUM_CAUSE);
  localparam int NUM_RANK  = 14;

  // Cause held at a given rank, rank 0 is the most urgent.
  function automatic int rank_cause(input int rank);
    case (rank)
      0:       return 3;
      1:       return 12;
      2:       return 1;
      3:       return 2;
      4:       return 0;
      5:       return 11;
      6:       return 9;
      7:       return 8;
      8:       return 6;
      9:       return 4;
      10:      return 15;
      11:      return 13;
      12:      return 7;
      13:      return 5;
      default: return 0;
    endcase
  endfunction

  // Defined causes are exactly those that appear in the ranking.
  function automatic logic [NUM_CAUSE-1:0] defined_causes();
    logic [NUM_CAUSE-1:0] m;
    m = '0;
    for (int r = 0; r < NUM_RANK; r++) m[rank_cause(r)] = 1'b1;
    return m;
  endfunction

  // Causes that originate on the instruction-fetch side.
  function automatic logic [NUM_CAUSE-1:0] fetch_side_causes();
    logic [NUM_CAUSE-1:0] m;
    m = '0;
    m[0]  = 1'b1;
    m[1]  = 1'b1;
    m[2]  = 1'b1;
    m[12] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/exc_flag_filter.sv
module exc_flag_filter
  import exc_sel_pkg::*;
#(
  parameter int N = NUM_CAUSE
) (
  input  logic [N-1:0] raw_flags,
  input  logic [N-1:0] enable_mask,
  input  logic         fetch_mode,
  output logic [N-1:0] kept_flags
);
  localparam logic [N-1:0] LEGAL = N'(defined_causes());
  localparam logic [N-1:0] FETCH = N'(fetch_side_causes());

  logic [N-1:0] mode_mask;

  always_comb begin
    mode_mask  = fetch_mode ? FETCH : {N{1'b1}};
    kept_flags = raw_flags & enable_mask & LEGAL & mode_mask;
  end
endmodule

// File: rtl/exc_rank_arbiter.sv
module exc_rank_arbiter
  import exc_sel_pkg::*;
#(
  parameter int N     = NUM_CAUSE,
  parameter int RANKS = NUM_RANK
) (
  input  logic [N-1:0] kept_flags,
  output logic [N-1:0] grant
);
  logic [RANKS-1:0] rank_hit;
  logic [RANKS:0]   claimed;
  logic [RANKS-1:0] rank_win;

  assign claimed[0] = 1'b0;

  for (genvar r = 0; r < RANKS; r++) begin : g_rank
    localparam int C = rank_cause(r);
    assign rank_hit[r]  = kept_flags[C];
    assign rank_win[r]  = rank_hit[r] & ~claimed[r];
    assign claimed[r+1] = claimed[r] | rank_hit[r];
  end

  always_comb begin
    grant = '0;
    for (int r = 0; r < RANKS; r++) begin
      grant[rank_cause(r)] = grant[rank_cause(r)] | rank_win[r];
    end
  end
endmodule

// File: rtl/exc_cause_encode.sv
module exc_cause_encode
  import exc_sel_pkg::*;
#(
  parameter int N = NUM_CAUSE,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] grant,
  output logic [W-1:0] cause
);
  always_comb begin
    cause = '0;
    for (int c = 0; c < N; c++) begin
      if (grant[c]) cause = cause | W'(c);
    end
  end
endmodule

// File: rtl/exc_cause_sel.sv
module exc_cause_sel
  import exc_sel_pkg::*;
#(
  parameter int N = NUM_CAUSE,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] exc_raised,
  input  logic [N-1:0] unit_cause_en,
  input  logic         fetch_only,
  output logic         exc_valid,
  output logic [W-1:0] exc_cause
);
  logic [N-1:0] kept_flags;
  logic [N-1:0] grant;

  exc_flag_filter #(.N(N)) u_filter (
    .raw_flags   (exc_raised),
    .enable_mask (unit_cause_en),
    .fetch_mode  (fetch_only),
    .kept_flags  (kept_flags)
  );

  exc_rank_arbiter #(.N(N), .RANKS(NUM_RANK)) u_arb (
    .kept_flags (kept_flags),
    .grant      (grant)
  );

  exc_cause_encode #(.N(N)) u_enc (
    .grant (grant),
    .cause (exc_cause)
  );

  assign exc_valid = |kept_flags;
endmodule

// File: rtl/exc_cause_sel_chk.sv
module exc_cause_sel_chk #(
  parameter int N = 16,
  parameter int W = 4
) (
  input logic [N-1:0] exc_raised,
  input logic [N-1:0] unit_cause_en,
  input logic         fetch_only,
  input logic [N-1:0] kept_flags,
  input logic [N-1:0] grant,
  input logic         exc_valid,
  input logic [W-1:0] exc_cause
);
  always_comb begin
    if (!$isunknown({exc_raised, unit_cause_en, fetch_only})) begin
      // R2
      onehot_grant_chk: assert ($onehot0(grant));
      // R6
      valid_grant_chk: assert (exc_valid == (grant != '0));
      // R7
      idle_cause_chk: assert (exc_valid || exc_cause == '0);
      // R1
      cause_raised_chk: assert (!exc_valid || (kept_flags[exc_cause] && exc_raised[exc_cause]));
      // R3
      undefined_cause_chk: assert (!exc_valid || (exc_cause != W'(10) && exc_cause != W'(14)));
      // R4
      fetch_mode_chk: assert (!(exc_valid && fetch_only) ||
                              exc_cause == W'(0) || exc_cause == W'(1) ||
                              exc_cause == W'(2) || exc_cause == W'(12));
      // R5
      enable_mask_chk: assert (!exc_valid || unit_cause_en[exc_cause]);
      // R2
      top_rank_chk: assert (!(exc_raised[3] && unit_cause_en[3] && !fetch_only) || exc_cause == W'(3));
    end
  end
endmodule

bind exc_cause_sel exc_cause_sel_chk #(.N(N), .W(W)) u_chk (
  .exc_raised    (exc_raised),
  .unit_cause_en (unit_cause_en),
  .fetch_only    (fetch_only),
  .kept_flags    (kept_flags),
  .grant         (grant),
  .exc_valid     (exc_valid),
  .exc_cause     (exc_cause)
);

// File: tb/test_exc_cause_sel.sv
`timescale 1ns/1ps
module test_exc_cause_sel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] exc_raised = '0;
  logic [15:0] unit_cause_en = '0;
  logic        fetch_only = 1'b0;
  logic        exc_valid;
  logic [3:0]  exc_cause;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  localparam int ORDER [14] = '{3, 12, 1, 2, 0, 11, 9, 8, 6, 4, 15, 13, 7, 5};

  always #2 clk = ~clk;

  exc_cause_sel i_exc_cause_sel (
    .exc_raised    (exc_raised),
    .unit_cause_en (unit_cause_en),
    .fetch_only    (fetch_only),
    .exc_valid     (exc_valid),
    .exc_cause     (exc_cause)
  );

  function automatic bit is_defined(input int c);
    return !(c == 10 || c == 14);
  endfunction

  function automatic bit is_fetch(input int c);
    return c == 0 || c == 1 || c == 2 || c == 12;
  endfunction

  // Walk the ranking and take the first flag that survives every mask.
  task automatic model(input logic [15:0] f, input logic [15:0] en, input logic fe,
                       output logic v, output logic [3:0] c);
    v = 1'b0;
    c = 4'd0;
    foreach (ORDER[k]) begin
      if (!v && f[ORDER[k]] && en[ORDER[k]] && (!fe || is_fetch(ORDER[k]))) begin
        v = 1'b1;
        c = 4'(ORDER[k]);
      end
    end
  endtask

  task automatic drive(input logic [15:0] f, input logic [15:0] en, input logic fe);
    @(negedge clk);
    exc_raised    = f;
    unit_cause_en = en;
    fetch_only    = fe;
    #1;
  endtask

  task automatic expect_out(input string req, input logic v, input logic [3:0] c);
    n_cmp++;
    if (exc_valid !== v || exc_cause !== c) begin
      n_bad++;
      $display("FAIL %s: flags=%h en=%h fe=%b got valid=%b cause=%0d expected valid=%b cause=%0d",
               req, exc_raised, unit_cause_en, fetch_only, exc_valid, exc_cause, v, c);
    end
  endtask

  task automatic check_model(input string req);
    logic v;
    logic [3:0] c;
    model(exc_raised, unit_cause_en, fetch_only, v, c);
    expect_out(req, v, c);
  endtask

  task automatic t_idle();
    drive('0, '1, 1'b0);
    expect_out("R6", 1'b0, 4'd0);
    drive('0, '0, 1'b1);
    expect_out("R7", 1'b0, 4'd0);
  endtask

  task automatic t_single();
    for (int c = 0; c < 16; c++) begin
      drive(16'(1) << c, '1, 1'b0);
      if (is_defined(c)) expect_out("R1", 1'b1, 4'(c));
      else               expect_out("R3", 1'b0, 4'd0);
    end
  endtask

  task automatic t_pairs();
    for (int i = 0; i < 14; i++) begin
      for (int j = i + 1; j < 14; j++) begin
        drive((16'(1) << ORDER[i]) | (16'(1) << ORDER[j]), '1, 1'b0);
        expect_out("R2", 1'b1, 4'(ORDER[i]));
      end
    end
    drive('1, '1, 1'b0);
    expect_out("R2", 1'b1, 4'd3);
  endtask

  task automatic t_undefined();
    drive(16'h4400, '1, 1'b0);
    expect_out("R3", 1'b0, 4'd0);
    drive(16'h4420, '1, 1'b0);
    expect_out("R3", 1'b1, 4'd5);
  endtask

  task automatic t_fetch();
    for (int c = 0; c < 16; c++) begin
      drive(16'(1) << c, '1, 1'b1);
      if (is_fetch(c)) expect_out("R4", 1'b1, 4'(c));
      else             expect_out("R4", 1'b0, 4'd0);
    end
    drive('1, '1, 1'b1);
    expect_out("R4", 1'b1, 4'd12);
    drive(16'hEFF8, '1, 1'b1);
    expect_out("R4", 1'b0, 4'd0);
  endtask

  task automatic t_enable();
    for (int c = 0; c < 16; c++) begin
      drive('1, 16'(1) << c, 1'b0);
      if (is_defined(c)) expect_out("R5", 1'b1, 4'(c));
      else               expect_out("R5", 1'b0, 4'd0);
    end
    drive('1, 16'hFFF7, 1'b0);
    expect_out("R5", 1'b1, 4'd12);
    drive('1, '0, 1'b0);
    expect_out("R5", 1'b0, 4'd0);
  endtask

  task automatic t_random();
    for (int k = 0; k < 400; k++) begin
      drive(16'($urandom), (k % 3 == 0) ? 16'hFFFF : 16'($urandom), 1'($urandom % 4 == 0));
      check_model("R2");
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_idle();
    t_single();
    t_pairs();
    t_undefined();
    t_fetch();
    t_enable();
    t_random();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule